// File: doc/BRIEF.md
# LPC Target Frame Front-End

This block sits at the target end of a Low Pin Count memory link. It watches an active-low chip select, an active-low frame strobe and the 4-bit LAD bus, and decides when a memory cycle aimed at this target begins. When the strobe returns high after a valid start nibble, it emits a one-cycle start pulse together with the captured nibble and holds an active-cycle flag. That flag stays up until the downstream nibble decoder reports the end of the cycle, or until the strobe drops again and breaks the frame.

A frame counts only if chip select was already low on the clock before the strobe was first seen low. Frames that arrive without that lead are skipped whole. Two active-low reset pins behave identically. Either one tri-states LAD at once. Held long enough, either one also returns the sequencer to its reset state and raises an abort to any internal program or erase that is running. A standby flag tells the power logic when nothing is in flight.

The sequencer has five states. FE_RESET is held while the filtered reset is active and leaves to FE_IDLE once it clears. FE_IDLE goes to FE_START when the strobe is low and chip select was low a clock earlier. It goes to FE_SKIP when the strobe is low without that lead. FE_START waits while the strobe stays low. On the first clock with the strobe high, it goes to FE_ACTIVE if the last nibble seen with the strobe low is the start code, and otherwise returns to FE_IDLE. FE_ACTIVE goes to FE_IDLE on the done input. A low strobe in FE_ACTIVE breaks the frame: the state goes to FE_START or FE_SKIP under the same chip-select rule as FE_IDLE. FE_SKIP returns to FE_IDLE when the strobe goes high.

Top module: `lpc_frame_fe`

## Requirements
- R1: The start nibble is the LAD value on the last clock with frame_n low. start_pulse is high for exactly one cycle, after the first clock edge that sees frame_n high, with start_code holding that nibble. cyc_active rises in the same cycle as start_pulse.
- R2: A frame is accepted only if ce_n was low at the clock edge before the one that first samples frame_n low. Otherwise the frame is skipped: no start_pulse, and cyc_active stays low.
- R3: Only the start code 4'b0000 opens a cycle. Any other nibble leaves the block idle with no start_pulse.
- R4: frame_n sampled low during an active cycle ends that cycle. cyc_active drops and frame_abort pulses for one cycle after that edge. The same strobe can open a new cycle under R1 and R2.
- R5: cyc_done sampled high during an active cycle returns the block to idle, and cyc_active drops after that edge.
- R6: lad_oe equals drv_req while a cycle is active and is 0 otherwise. lad_oe is 0 at once, with no clock needed, whenever either reset pin is low.
- R7: A reset pin takes effect only after it passes a two-flop synchronizer and is then seen low on RST_HOLD (default 4) consecutive clock edges. Once in effect, it ends any cycle. A shorter low pulse leaves the active cycle untouched.
- R8: op_abort is high while the filtered reset is in effect and op_busy is high, and is low otherwise.
- R9: standby is high only when the block is idle, op_busy is low, and either ce_n or frame_n is high.
- R10: rst_a_n and rst_b_n have identical effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_a_n | input | 1 | Reset pin A, active low |
| rst_b_n | input | 1 | Reset pin B, active low, same function as A |
| ce_n | input | 1 | Chip select, active low |
| frame_n | input | 1 | Frame strobe, active low |
| lad_in | input | 4 | LAD bus as seen at the input buffer |
| cyc_done | input | 1 | Downstream decoder reports the cycle has ended |
| drv_req | input | 1 | Downstream decoder asks to drive LAD |
| op_busy | input | 1 | Internal program or erase in progress |
| start_pulse | output | 1 | One-cycle pulse when a cycle opens |
| start_code | output | 4 | Start nibble captured for the cycle |
| frame_abort | output | 1 | One-cycle pulse when an active cycle is broken |
| cyc_active | output | 1 | A cycle is in progress |
| standby | output | 1 | Nothing in flight; low-power state allowed |
| lad_oe | output | 1 | LAD output-driver enable |
| op_abort | output | 1 | Abort request to the internal write engine |

## Verification
The checker tests the following on every clock:
- a start pulse always follows a low-then-high strobe edge and always carries the start code;
- a low strobe during an active cycle always drops the cycle and raises the abort pulse;
- LAD is released whenever a reset pin is low;
- op_abort never appears without op_busy;
- standby never overlaps an active cycle or a busy write engine;
- the filtered reset always clears the active flag.

Only the bench scenarios can show the rules that depend on history across several inputs. These are the one-clock chip-select lead, which nibble wins in a multi-cycle strobe, the glitch filter's minimum hold length, and the equal effect of both reset pins.

// File: rtl/lpc_fe_pkg.sv
package lpc_fe_pkg;

    typedef enum logic [2:0] {
        FE_RESET  = 3'd0,
        FE_IDLE   = 3'd1,
        FE_START  = 3'd2,
        FE_ACTIVE = 3'd3,
        FE_SKIP   = 3'd4
    } fe_state_e;

endpackage

// File: rtl/lpc_rst_filter.sv
module lpc_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CLKS   = 4
) (
    input  logic clk,
    input  logic rst_a_n,
    input  logic rst_b_n,
    output logic pins_ok,
    output logic rst_eff
);

    logic                   raw_n;
    logic [SYNC_STAGES-1:0] sync_q;
    logic [HOLD_CLKS-1:0]   hold_q;

    assign raw_n   = rst_a_n & rst_b_n;
    assign pins_ok = raw_n;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
    end

    generate
        if (HOLD_CLKS == 1) begin : g_hold_one
            always_ff @(posedge clk) begin
                hold_q <= sync_q[SYNC_STAGES-1];
            end
        end else begin : g_hold_many
            always_ff @(posedge clk) begin
                hold_q <= {hold_q[HOLD_CLKS-2:0], sync_q[SYNC_STAGES-1]};
            end
        end
    endgenerate

    // Reset counts only once every stage of the hold window saw it low.
    assign rst_eff = ~|hold_q;

endmodule

// File: rtl/lpc_start_cap.sv
module lpc_start_cap #(
    parameter int LAD_W = 4
) (
    input  logic             clk,
    input  logic             frame_n,
    input  logic             ce_n,
    input  logic [LAD_W-1:0] lad_in,
    output logic [LAD_W-1:0] lad_last,
    output logic             ce_prev_n
);

    always_ff @(posedge clk) begin
        ce_prev_n <= ce_n;
        if (!frame_n) begin
            lad_last <= lad_in;
        end
    end

endmodule

// File: rtl/lpc_frame_fsm.sv
module lpc_frame_fsm
    import lpc_fe_pkg::*;
#(
    parameter int              LAD_W      = 4,
    parameter logic [LAD_W-1:0] START_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_eff,
    input  logic             frame_n,
    input  logic             ce_prev_n,
    input  logic [LAD_W-1:0] lad_last,
    input  logic             cyc_done,
    output fe_state_e        state,
    output logic             start_pulse,
    output logic [LAD_W-1:0] start_code,
    output logic             frame_abort
);

    fe_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FE_RESET: state_nx = FE_IDLE;
            FE_IDLE: begin
                if (!frame_n) state_nx = ce_prev_n ? FE_SKIP : FE_START;
            end
            FE_START: begin
                if (frame_n) state_nx = (lad_last == START_CODE) ? FE_ACTIVE : FE_IDLE;
            end
            FE_ACTIVE: begin
                if (!frame_n)     state_nx = ce_prev_n ? FE_SKIP : FE_START;
                else if (cyc_done) state_nx = FE_IDLE;
            end
            FE_SKIP: begin
                if (frame_n) state_nx = FE_IDLE;
            end
            default: state_nx = FE_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_eff) state <= FE_RESET;
        else         state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst_eff) begin
            start_pulse <= 1'b0;
            start_code  <= '0;
            frame_abort <= 1'b0;
        end else begin
            start_pulse <= (state == FE_START) && (state_nx == FE_ACTIVE);
            if ((state == FE_START) && (state_nx == FE_ACTIVE)) begin
                start_code <= lad_last;
            end
            frame_abort <= (state == FE_ACTIVE) && !frame_n;
        end
    end

endmodule

// File: rtl/lpc_frame_fe.sv
module lpc_frame_fe
    import lpc_fe_pkg::*;
#(
    parameter int LAD_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RST_HOLD    = 4
) (
    input  logic             clk,
    input  logic             rst_a_n,
    input  logic             rst_b_n,
    input  logic             ce_n,
    input  logic             frame_n,
    input  logic [LAD_W-1:0] lad_in,
    input  logic             cyc_done,
    input  logic             drv_req,
    input  logic             op_busy,
    output logic             start_pulse,
    output logic [LAD_W-1:0] start_code,
    output logic             frame_abort,
    output logic             cyc_active,
    output logic             standby,
    output logic             lad_oe,
    output logic             op_abort
);

    localparam logic [LAD_W-1:0] MEM_START = '0;

    logic             pins_ok;
    logic             rst_eff;
    logic [LAD_W-1:0] lad_last;
    logic             ce_prev_n;
    fe_state_e        state;

    lpc_rst_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CLKS   (RST_HOLD)
    ) u_rst (
        .clk     (clk),
        .rst_a_n (rst_a_n),
        .rst_b_n (rst_b_n),
        .pins_ok (pins_ok),
        .rst_eff (rst_eff)
    );

    lpc_start_cap #(.LAD_W(LAD_W)) u_cap (
        .clk       (clk),
        .frame_n   (frame_n),
        .ce_n      (ce_n),
        .lad_in    (lad_in),
        .lad_last  (lad_last),
        .ce_prev_n (ce_prev_n)
    );

    lpc_frame_fsm #(
        .LAD_W      (LAD_W),
        .START_CODE (MEM_START)
    ) u_fsm (
        .clk         (clk),
        .rst_eff     (rst_eff),
        .frame_n     (frame_n),
        .ce_prev_n   (ce_prev_n),
        .lad_last    (lad_last),
        .cyc_done    (cyc_done),
        .state       (state),
        .start_pulse (start_pulse),
        .start_code  (start_code),
        .frame_abort (frame_abort)
    );

    assign cyc_active = (state == FE_ACTIVE);
    assign standby    = (state == FE_IDLE) && !op_busy && (ce_n || frame_n);
    assign lad_oe     = pins_ok && cyc_active && drv_req;
    assign op_abort   = rst_eff && op_busy;

endmodule

// File: rtl/lpc_frame_fe_chk.sv
module lpc_frame_fe_chk #(
    parameter int LAD_W = 4
) (
    input logic             clk,
    input logic             rst_eff,
    input logic             rst_a_n,
    input logic             rst_b_n,
    input logic             frame_n,
    input logic             op_busy,
    input logic             start_pulse,
    input logic [LAD_W-1:0] start_code,
    input logic             frame_abort,
    input logic             cyc_active,
    input logic             standby,
    input logic             lad_oe,
    input logic             op_abort
);

    assert_start_edge_R1: assert property (@(posedge clk) disable iff (rst_eff)
        start_pulse |-> ($past(frame_n) && !$past(frame_n, 2)));

    assert_start_code_R3: assert property (@(posedge clk) disable iff (rst_eff)
        start_pulse |-> (start_code == '0));

    assert_break_R4: assert property (@(posedge clk) disable iff (rst_eff)
        (cyc_active && !frame_n) |=> (!cyc_active && frame_abort));

    assert_lad_release_R6: assert property (@(posedge clk)
        !(rst_a_n && rst_b_n) |-> !lad_oe);

    assert_rst_ends_R7: assert property (@(posedge clk)
        rst_eff |=> !cyc_active);

    assert_abort_busy_R8: assert property (@(posedge clk)
        op_abort |-> op_busy);

    assert_standby_R9: assert property (@(posedge clk) disable iff (rst_eff)
        standby |-> (!cyc_active && !op_busy));

endmodule

bind lpc_frame_fe lpc_frame_fe_chk #(.LAD_W(LAD_W)) u_chk (
    .clk         (clk),
    .rst_eff     (rst_eff),
    .rst_a_n     (rst_a_n),
    .rst_b_n     (rst_b_n),
    .frame_n     (frame_n),
    .op_busy     (op_busy),
    .start_pulse (start_pulse),
    .start_code  (start_code),
    .frame_abort (frame_abort),
    .cyc_active  (cyc_active),
    .standby     (standby),
    .lad_oe      (lad_oe),
    .op_abort    (op_abort)
);

// File: tb/lpc_frame_fe_tb.sv
`timescale 1ns/1ps
module lpc_frame_fe_tb;

    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_a_n, rst_b_n, ce_n, frame_n, cyc_done, drv_req, op_busy;
    logic [3:0] lad_in;
    logic       start_pulse, frame_abort, cyc_active, standby, lad_oe, op_abort;
    logic [3:0] start_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lpc_frame_fe #(.RST_HOLD(HOLD)) u_dut (
        .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .ce_n(ce_n),
        .frame_n(frame_n), .lad_in(lad_in), .cyc_done(cyc_done),
        .drv_req(drv_req), .op_busy(op_busy), .start_pulse(start_pulse),
        .start_code(start_code), .frame_abort(frame_abort),
        .cyc_active(cyc_active), .standby(standby), .lad_oe(lad_oe),
        .op_abort(op_abort)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Assumes ce_n has been low for at least one clock; ends one cycle after
    // the start pulse should appear.
    task automatic open_cycle(input string req);
        @(negedge clk); frame_n = 1'b0; lad_in = 4'h0;
        @(negedge clk); frame_n = 1'b1; lad_in = 4'hF;
        chk({req, " pulse not early"}, start_pulse, 1'b0);
        @(negedge clk);
        chk({req, " pulse"}, start_pulse, 1'b1);
        chk({req, " code"}, start_code, 4'h0);
        chk({req, " active"}, cyc_active, 1'b1);
    endtask

    task automatic close_cycle();
        cyc_done = 1'b1;
        @(negedge clk); cyc_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_a_n = 0; rst_b_n = 0; ce_n = 1; frame_n = 1; lad_in = 4'hF;
        cyc_done = 0; drv_req = 0; op_busy = 0;
        ticks(10);
        rst_a_n = 1; rst_b_n = 1;
        ticks(6);
        chk("R7 reset active", cyc_active, 1'b0);
        chk("R7 reset pulse", start_pulse, 1'b0);
        chk("R6 reset oe", lad_oe, 1'b0);
        chk("R9 reset standby", standby, 1'b1);
    endtask

    task automatic t_basic();
        @(negedge clk); ce_n = 1'b0;
        open_cycle("R1");
        @(negedge clk);
        chk("R1 single pulse", start_pulse, 1'b0);
        chk("R1 still active", cyc_active, 1'b1);
        close_cycle();
        chk("R5 done idles", cyc_active, 1'b0);
    endtask

    task automatic t_multi_low();
        // last low nibble is 0 -> cycle opens
        @(negedge clk); frame_n = 0; lad_in = 4'h5;
        @(negedge clk); lad_in = 4'h0;
        @(negedge clk); frame_n = 1; lad_in = 4'hF;
        @(negedge clk);
        chk("R1 last nibble wins", start_pulse, 1'b1);
        close_cycle();
        // last low nibble is 5 -> nothing
        @(negedge clk); frame_n = 0; lad_in = 4'h0;
        @(negedge clk); lad_in = 4'h5;
        @(negedge clk); frame_n = 1; lad_in = 4'hF;
        @(negedge clk);
        chk("R3 late bad nibble", start_pulse, 1'b0);
        chk("R3 late bad nibble idle", cyc_active, 1'b0);
    endtask

    task automatic t_bad_code();
        @(negedge clk); frame_n = 0; lad_in = 4'hD;
        @(negedge clk); frame_n = 1; lad_in = 4'hF;
        @(negedge clk);
        chk("R3 bad code pulse", start_pulse, 1'b0);
        @(negedge clk);
        chk("R3 bad code idle", cyc_active, 1'b0);
    endtask

    task automatic t_ce_late();
        @(negedge clk); ce_n = 1;
        ticks(2);
        ce_n = 0; frame_n = 0; lad_in = 4'h0;
        @(negedge clk); frame_n = 1; lad_in = 4'hF;
        @(negedge clk);
        chk("R2 late ce pulse", start_pulse, 1'b0);
        chk("R2 late ce active", cyc_active, 1'b0);
        open_cycle("R2 after lead");
        close_cycle();
    endtask

    task automatic t_broken();
        open_cycle("R4 setup");
        @(negedge clk); frame_n = 0; lad_in = 4'h0;
        @(negedge clk);
        chk("R4 abort pulse", frame_abort, 1'b1);
        chk("R4 active drops", cyc_active, 1'b0);
        frame_n = 1; lad_in = 4'hF;
        @(negedge clk);
        chk("R4 restart pulse", start_pulse, 1'b1);
        chk("R4 abort single", frame_abort, 1'b0);
        // break with chip select gone high
        @(negedge clk); ce_n = 1;
        @(negedge clk); frame_n = 0; lad_in = 4'h0;
        @(negedge clk);
        chk("R4 abort no ce", frame_abort, 1'b1);
        frame_n = 1;
        @(negedge clk);
        chk("R2 no restart without ce", start_pulse, 1'b0);
        chk("R2 skipped idle", cyc_active, 1'b0);
        ce_n = 0;
        @(negedge clk);
    endtask

    task automatic t_standby();
        ce_n = 1; op_busy = 0;
        #1 chk("R9 idle standby", standby, 1'b1);
        op_busy = 1;
        #1 chk("R9 busy no standby", standby, 1'b0);
        op_busy = 0; ce_n = 0;
        #1 chk("R9 frame high standby", standby, 1'b1);
        @(negedge clk);
        open_cycle("R9 setup");
        chk("R9 active no standby", standby, 1'b0);
        close_cycle();
    endtask

    task automatic t_oe();
        drv_req = 1;
        #1 chk("R6 idle no drive", lad_oe, 1'b0);
        @(negedge clk);
        open_cycle("R6 setup");
        #1 chk("R6 drive active", lad_oe, 1'b1);
        drv_req = 0;
        #1 chk("R6 drive released", lad_oe, 1'b0);
        drv_req = 1;
        rst_b_n = 0;
        #1 chk("R6 pin b hi-z", lad_oe, 1'b0);
        rst_b_n = 1;
        rst_a_n = 0;
        #1 chk("R6 pin a hi-z", lad_oe, 1'b0);
        rst_a_n = 1;
        #1 chk("R6 drive back", lad_oe, 1'b1);
    endtask

    task automatic t_glitch();
        // cycle still active from t_oe, drv_req high
        op_busy = 1;
        @(negedge clk); rst_b_n = 0;
        ticks(HOLD - 1);
        rst_b_n = 1;
        ticks(6);
        chk("R7 short pulse keeps cycle", cyc_active, 1'b1);
        chk("R8 short pulse no abort", op_abort, 1'b0);
        chk("R7 oe restored", lad_oe, 1'b1);
        op_busy = 0; drv_req = 0;
    endtask

    task automatic t_full_a();
        op_busy = 1;
        @(negedge clk); rst_a_n = 0;
        ticks(8);
        chk("R7 pin a ends cycle", cyc_active, 1'b0);
        chk("R8 abort during reset", op_abort, 1'b1);
        chk("R9 no standby in reset", standby, 1'b0);
        op_busy = 0;
        #1 chk("R8 abort follows busy", op_abort, 1'b0);
        op_busy = 1;
        rst_a_n = 1;
        ticks(6);
        chk("R8 abort gone after reset", op_abort, 1'b0);
        chk("R7 idle after reset", cyc_active, 1'b0);
        op_busy = 0;
        #1 chk("R9 standby after reset", standby, 1'b1);
    endtask

    task automatic t_full_b();
        @(negedge clk);
        open_cycle("R10 setup");
        rst_b_n = 0;
        ticks(8);
        chk("R10 pin b ends cycle", cyc_active, 1'b0);
        rst_b_n = 1;
        ticks(6);
        open_cycle("R10 after pin b");
        close_cycle();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_multi_low();
        t_bad_code();
        t_ce_late();
        t_broken();
        close_cycle();
        t_standby();
        t_oe();
        t_glitch();
        t_full_a();
        t_full_b();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule